// File: doc/BRIEF.md
# Vector Lane Transpose Unit

This block performs the transpose step of a vector permute engine. Two source vectors of up to 128 bits arrive with a lane-width code, a width-select bit and a 3-bit operation code. For each pair of output lanes, the block takes the same source lane from both operands, either the even one or the odd one of the pair, and places the first operand's copy in the lower lane and the second operand's copy in the upper lane. One registered result comes out for each accepted request.

Lane width is 8 bits shifted left by the 2-bit width code (8, 16, 32 or 64 bits). The vector width is 64 bits when the width-select bit is 0 and 128 bits when it is 1. A request for 64-bit lanes on a 64-bit vector is malformed and is flagged as illegal. Operation codes other than the two transpose codes are flagged as unsupported. A flagged request leaves the result unchanged.

Top module: `vtrn_unit`

## Requirements
- R1: A synchronous active-high reset clears the result to zero and clears the valid, illegal and unsupported outputs.
- R2: When `in_valid` is high, the outputs show the request's outcome on the next rising clock edge. When `in_valid` is low, valid and both error flags are low on the next edge and the result holds its value.
- R3: Opcode 3'b010 (even variant, part = opcode bit 2 = 0): output lane 2p takes lane 2p of `src_a`, and output lane 2p+1 takes lane 2p of `src_b`, for every pair p.
- R4: Opcode 3'b110 (odd variant, part = 1): output lane 2p takes lane 2p+1 of `src_a`, and output lane 2p+1 takes lane 2p+1 of `src_b`.
- R5: The lane width is 8 << `lane_code` bits (codes 00, 01, 10, 11 give 8, 16, 32, 64). The number of pairs is half of the vector width divided by the lane width.
- R6: With `wide` = 0 the vector is 64 bits wide and bits 127:64 of the result are zero. With `wide` = 1 the vector is 128 bits wide.
- R7: `lane_code` = 11 with `wide` = 0 raises `illegal_o` for a transpose opcode. Valid stays low and the result keeps its previous value.
- R8: Any opcode other than 010 or 110 raises `unsupported_o`. Valid stays low and the result keeps its previous value.
- R9: At most one of `valid_o`, `illegal_o` and `unsupported_o` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| src_a | input | 128 | First operand |
| src_b | input | 128 | Second operand |
| lane_code | input | 2 | Lane width code |
| wide | input | 1 | 0 selects a 64-bit vector, 1 selects a 128-bit vector |
| opcode | input | 3 | Operation code |
| result_o | output | 128 | Registered result |
| valid_o | output | 1 | Result written this cycle |
| illegal_o | output | 1 | Malformed width combination |
| unsupported_o | output | 1 | Opcode not handled |

## Verification
The hardest case to reach is an error that arrives right after a good result. The bench issues a known transpose first, then an illegal request and an unsupported request, each with operands that would otherwise give a different result. It then checks that `result_o` still holds the earlier value. The upper half is tested for zero by sending all-ones operands with `wide` = 0, right after a 128-bit result that filled the upper half.

// File: rtl/vtrn_pkg.sv
package vtrn_pkg;
   localparam int unsigned MAX_W    = 128;
   localparam int unsigned NARROW_W = 64;
   localparam int unsigned BASE_LW  = 8;
   localparam int unsigned N_CODES  = 4;
   localparam logic [2:0] OP_EVEN = 3'b010;
   localparam logic [2:0] OP_ODD  = 3'b110;

   typedef enum logic [1:0] {
      ST_OK    = 2'd0,
      ST_ILL   = 2'd1,
      ST_UNSUP = 2'd2
   } vtrn_status_e;
endpackage

// File: rtl/vtrn_lanes.sv
// Transpose for one fixed lane width. The narrow mode zeroes the upper half.
module vtrn_lanes #(
   parameter int unsigned W  = 128,
   parameter int unsigned LW = 8
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic         part,
   input  logic         narrow,
   output logic [W-1:0] y
);
   localparam int unsigned LANES = W / LW;
   localparam int unsigned PAIRS = LANES / 2;
   localparam int unsigned HALF_PAIRS = PAIRS / 2;

   initial begin
      if (LW == 0 || (W % (2 * LW)) != 0)
         $error("vtrn_lanes: width must be a multiple of two lanes");
   end

   for (genvar p = 0; p < PAIRS; p++) begin : g_pair
      logic [LW-1:0] ea, eb;
      logic          keep;
      assign keep = !narrow || (p < HALF_PAIRS);
      assign ea = part ? a[(2*p+1)*LW +: LW] : a[(2*p)*LW +: LW];
      assign eb = part ? b[(2*p+1)*LW +: LW] : b[(2*p)*LW +: LW];
      assign y[(2*p)*LW   +: LW] = keep ? ea : '0;
      assign y[(2*p+1)*LW +: LW] = keep ? eb : '0;
   end
endmodule

// File: rtl/vtrn_decode.sv
module vtrn_decode
   import vtrn_pkg::*;
(
   input  logic [1:0]   lane_code,
   input  logic         wide,
   input  logic [2:0]   opcode,
   output vtrn_status_e status,
   output logic         part
);
   assign part = opcode[2];
   always_comb begin
      if (opcode != OP_EVEN && opcode != OP_ODD) status = ST_UNSUP;
      else if ({lane_code, wide} == 3'b110)      status = ST_ILL;
      else                                       status = ST_OK;
   end
endmodule

// File: rtl/vtrn_unit.sv
module vtrn_unit
   import vtrn_pkg::*;
#(
   parameter int unsigned W = MAX_W
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         in_valid,
   input  logic [W-1:0] src_a,
   input  logic [W-1:0] src_b,
   input  logic [1:0]   lane_code,
   input  logic         wide,
   input  logic [2:0]   opcode,
   output logic [W-1:0] result_o,
   output logic         valid_o,
   output logic         illegal_o,
   output logic         unsupported_o
);
   localparam int unsigned NW = W / 2;

   initial begin
      if (W != 2 * NARROW_W) $error("vtrn_unit: W must be twice the narrow width");
   end

   vtrn_status_e st;
   logic         part;
   logic [W-1:0] cand [N_CODES];
   logic [W-1:0] sel;

   vtrn_decode u_dec (
      .lane_code(lane_code), .wide(wide), .opcode(opcode),
      .status(st), .part(part)
   );

   for (genvar c = 0; c < N_CODES; c++) begin : g_width
      if ((BASE_LW << c) < NW) begin : g_any
         vtrn_lanes #(.W(W), .LW(BASE_LW << c)) u_l (
            .a(src_a), .b(src_b), .part(part), .narrow(!wide), .y(cand[c])
         );
      end else begin : g_wide_only
         // 64-bit lanes: a single pair over the full width. The narrow case is illegal.
         vtrn_lanes #(.W(W), .LW(BASE_LW << c)) u_l (
            .a(src_a), .b(src_b), .part(part), .narrow(1'b0), .y(cand[c])
         );
      end
   end

   assign sel = cand[lane_code];

   always_ff @(posedge clk) begin
      if (rst) begin
         result_o      <= '0;
         valid_o       <= 1'b0;
         illegal_o     <= 1'b0;
         unsupported_o <= 1'b0;
      end else begin
         valid_o       <= in_valid && (st == ST_OK);
         illegal_o     <= in_valid && (st == ST_ILL);
         unsupported_o <= in_valid && (st == ST_UNSUP);
         if (in_valid && st == ST_OK) result_o <= sel;
      end
   end
endmodule

// File: rtl/vtrn_unit_chk.sv
module vtrn_unit_chk #(
   parameter int unsigned W = 128
) (
   input logic         clk,
   input logic         rst,
   input logic         in_valid,
   input logic [1:0]   lane_code,
   input logic         wide,
   input logic [2:0]   opcode,
   input logic [W-1:0] result_o,
   input logic         valid_o,
   input logic         illegal_o,
   input logic         unsupported_o
);
   assert_flags_onehot_R9: assert property (@(posedge clk) disable iff (rst)
      $countones({valid_o, illegal_o, unsupported_o}) <= 1);
   assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> !valid_o && !illegal_o && !unsupported_o && $stable(result_o));
   assert_illegal_R7: assert property (@(posedge clk) disable iff (rst)
      in_valid && (opcode == 3'b010 || opcode == 3'b110) && lane_code == 2'b11 && !wide
      |=> illegal_o && !valid_o && $stable(result_o));
   assert_unsup_R8: assert property (@(posedge clk) disable iff (rst)
      in_valid && opcode != 3'b010 && opcode != 3'b110
      |=> unsupported_o && !valid_o && $stable(result_o));
   assert_narrow_upper_R6: assert property (@(posedge clk) disable iff (rst)
      in_valid && !wide && lane_code != 2'b11 && (opcode == 3'b010 || opcode == 3'b110)
      |=> valid_o && result_o[W-1:W/2] == '0);
   assert_reset_R1: assert property (@(posedge clk)
      rst |=> !valid_o && !illegal_o && !unsupported_o && result_o == '0);
endmodule

bind vtrn_unit vtrn_unit_chk #(.W(W)) u_chk (
   .clk(clk), .rst(rst), .in_valid(in_valid), .lane_code(lane_code), .wide(wide),
   .opcode(opcode), .result_o(result_o), .valid_o(valid_o), .illegal_o(illegal_o),
   .unsupported_o(unsupported_o)
);

// File: tb/vtrn_unit_bench.sv
`timescale 1ns/1ps
module vtrn_unit_bench;
   logic clk = 0, rst = 1, in_valid = 0, wide = 0;
   logic [127:0] src_a = '0, src_b = '0, result_o;
   logic [1:0] lane_code = '0;
   logic [2:0] opcode = '0;
   logic valid_o, illegal_o, unsupported_o;
   int tests = 0, fails = 0;

   always #5 clk = ~clk;

   vtrn_unit u_vtrn_unit (.*);

   initial begin
      #1_000_000;
      fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   function automatic logic [127:0] model(logic [127:0] a, logic [127:0] b,
                                          int lc, logic w, logic prt);
      logic [127:0] r = '0;
      int lw = 8 << lc;
      int pairs = ((w ? 128 : 64) / lw) / 2;
      for (int p = 0; p < pairs; p++)
         for (int k = 0; k < lw; k++) begin
            r[(2*p)*lw + k]   = a[(2*p+prt)*lw + k];
            r[(2*p+1)*lw + k] = b[(2*p+prt)*lw + k];
         end
      return r;
   endfunction

   task automatic check(string req, logic [127:0] act, logic [127:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic issue(logic [127:0] a, logic [127:0] b, logic [1:0] lc, logic w, logic [2:0] op);
      @(negedge clk);
      src_a = a; src_b = b; lane_code = lc; wide = w; opcode = op; in_valid = 1;
      @(negedge clk);
      in_valid = 0;
   endtask

   task automatic t_reset;
      check("R1 result", result_o, '0);
      check("R1 flags", {125'd0, valid_o, illegal_o, unsupported_o}, '0);
   endtask

   task automatic t_transpose(logic [127:0] a, logic [127:0] b, int lc, logic w, logic [2:0] op, string req);
      issue(a, b, lc[1:0], w, op);
      check(req, result_o, model(a, b, lc, w, op[2]));
      check({req, " valid"}, {127'd0, valid_o}, 128'd1);
   endtask

   task automatic t_errors;
      logic [127:0] held;
      t_transpose({4{32'h0123_4567}} ^ 128'h55, ~128'h0, 3, 1, 3'b010, "R3 R5 64b lanes");
      held = result_o;
      issue('1, '0, 2'b11, 1'b0, 3'b110);
      check("R7 flag", {126'd0, illegal_o, valid_o}, 128'd2);
      check("R7 held", result_o, held);
      issue('0, '1, 2'b00, 1'b1, 3'b011);
      check("R8 flag", {126'd0, unsupported_o, valid_o}, 128'd2);
      check("R8 held", result_o, held);
      issue('0, '1, 2'b11, 1'b0, 3'b000);
      check("R8 unsup priority", {125'd0, unsupported_o, illegal_o, valid_o}, 128'd4);
      @(negedge clk);
      check("R2 idle", {125'd0, valid_o, illegal_o, unsupported_o}, '0);
      check("R2 idle hold", result_o, held);
   endtask

   initial begin
      logic [127:0] pa = 128'h0f0e0d0c0b0a09080706050403020100;
      logic [127:0] pb = 128'h1f1e1d1c1b1a19181716151413121110;
      repeat (3) @(negedge clk);
      rst = 0;
      @(negedge clk);
      t_reset();
      t_transpose(pa, pb, 0, 1, 3'b010, "R3 8b wide");
      check("R3 literal", result_o, 128'h1e0e1c0c1a0a18081606140412021000);
      t_transpose(pa, pb, 0, 1, 3'b110, "R4 8b wide");
      check("R4 literal", result_o, 128'h1f0f1d0d1b0b19091707150513031101);
      t_transpose(pa, pb, 1, 1, 3'b110, "R4 R5 16b");
      t_transpose(pa, pb, 2, 1, 3'b010, "R3 R5 32b");
      t_transpose(pa, pb, 3, 1, 3'b110, "R4 R5 64b");
      t_transpose('1, '1, 0, 0, 3'b010, "R6 narrow 8b");
      check("R6 upper zero", {64'd0, result_o[127:64]}, '0);
      t_transpose(pa, pb, 2, 0, 3'b110, "R6 narrow 32b");
      t_transpose(pa, pb, 1, 0, 3'b010, "R6 narrow 16b");
      t_errors();
      @(negedge clk);
      rst = 1;
      @(negedge clk);
      rst = 0;
      t_reset();
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule